// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block produces the scan timing for a passive dot-matrix LCD panel, in either monochrome or colour. Each line is made of active shift-clock slots, each carrying one 8-bit data group on two 4-bit nibble buses. Blank slots follow the active slots, and the first blank slot carries the line latch pulse. The frame start output marks the first line of every frame. A backplane bias output toggles on a programmable line count. In one colour format that same output becomes a second shift clock instead.

Pixel groups arrive on a ready/valid stream, one group per active slot. If the stream has no group ready in time, the previous group is repeated and a sticky underrun flag is set. The panel enable output stays low until the first full frame has been scanned, and every panel output is held low until then. The configuration inputs must stay static while the block is out of reset.

A shift slot is two core clocks long. The shift clock is high in the first clock and low in the second. The panel captures data on the falling edge. Every panel output is registered, so a slot appears on the pins one core clock after the internal counters reach it.

Top module: `lcd_panel_timing`

## Requirements
- R1: While reset is asserted and on the first clock after it, every panel output, `pan_en`, `underrun` and `s_ready` are 0.
- R2: Modes 0 and 1 shift clock. A line has G = `cfg_hdots` / pixels-per-group active slots. In each active slot `pan_shift` is 1 for one core clock and then 0 for one core clock. The data buses change only when `pan_shift` rises.
- R3: `pan_latch` is 1 for exactly the two core clocks of the first blank slot. `pan_shift` stays 1 through every blank slot. `cfg_hblank` must be at least 2.
- R4: `pan_frame` is 1 for the whole of the first line of each frame, including across the fall of `pan_latch`, and 0 on every other line. The frame has `cfg_lines` lines, after which the line count wraps to line 0.
- R5: With `cfg_mod_lines` = 0 and `cfg_mode` not 2, `pan_mod` toggles once per frame. It starts at 0.
- R6: With `cfg_mod_lines` = N > 0 and `cfg_mode` not 2, `pan_mod` toggles after every N line periods.
- R7: `cfg_mode` = 0 selects 4-bit single panels at 4 pixels per group. In this mode `pan_ld` is always 0 and only `pan_ud` carries data.
- R8: `cfg_mode` = 2 selects the dual-clock colour format at 8 dots per group. Even-numbered groups of a line (counting from 0) pulse `pan_shift`, and odd-numbered groups pulse `pan_mod`. Each clock idles at 1 outside its own groups and during blank slots.
- R9: `pan_en` rises once the first full frame has been scanned and then stays 1. While `pan_en` is 0, all other panel outputs are 0.
- R10: `s_ready` is 1 for one core clock, one clock before each active slot of an enabled line. A group accepted then is driven on `pan_ud` (bits 7:4) and, outside mode 0, on `pan_ld` (bits 3:0) for the whole slot. `cfg_mode` = 1 (or 3) selects 8 pixels per group.
- R11: If `s_valid` is 0 while `s_ready` is 1, the previous group is driven again and `underrun` becomes 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0: 4-bit single, 1/3: 8-bit single, 2: 8-bit dual-clock colour |
| cfg_hdots | input | HDOT_W | Dots per line, a multiple of the group size |
| cfg_hblank | input | BLANK_W | Blank slots per line (at least 2) |
| cfg_lines | input | LINE_W | Lines per frame (at least 1) |
| cfg_mod_lines | input | MODCNT_W | Bias toggle period in lines, 0 = once per frame |
| s_valid | input | 1 | Pixel group offered |
| s_data | input | 8 | Pixel group |
| s_ready | output | 1 | Group taken this clock |
| pan_ud | output | 4 | Upper data nibble |
| pan_ld | output | 4 | Lower data nibble |
| pan_shift | output | 1 | Pixel shift clock |
| pan_latch | output | 1 | Line latch pulse |
| pan_mod | output | 1 | Backplane bias or second shift clock |
| pan_frame | output | 1 | Frame start marker |
| pan_en | output | 1 | Panel enable |
| underrun | output | 1 | Sticky stream underrun flag |

## Verification
The bench keeps the default parameter widths but drives small configurations: 1 to 6 groups per line, 2 to 5 blank slots and 1 to 5 lines. With these sizes a frame lasts only tens of clocks, so the enable point, many frame wraps and several bias toggle periods all fit into each run. Single-line frames and single-group lines are included, and so are bias periods shorter and longer than a frame. Underrun is exercised both by a stream that is never valid and by random gaps in the stream.

// File: rtl/lcd_timing_pkg.sv
// Shared definitions for the passive LCD timing generator.
// Assumes: the mode encoding below is fixed at the port boundary.
package lcd_timing_pkg;

    typedef enum logic [1:0] {
        MODE_MONO4      = 2'd0,
        MODE_MONO8      = 2'd1,
        MODE_COLOR_DUAL = 2'd2,
        MODE_ALT8       = 2'd3
    } panel_mode_e;

    // log2 of the dots carried by one 8-bit group in a given mode
    function automatic logic [1:0] group_shift(input logic [1:0] mode);
        return (mode == MODE_MONO4) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/lcd_scan_counter.sv
// Phase / slot / line counters for the panel scan.
// A slot is two clocks (phase 0, phase 1). A line has groups + blank slots.
// A frame has 'lines' lines.
// Assumes: groups >= 1, blank >= 2, lines >= 1, all static out of reset.
module lcd_scan_counter #(
    parameter int HDOT_W  = 10,
    parameter int BLANK_W = 4,
    parameter int LINE_W  = 9,
    parameter int SLOT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HDOT_W-1:0] groups,
    input  logic [BLANK_W-1:0] blank,
    input  logic [LINE_W-1:0] lines,
    output logic              phase,
    output logic              active,
    output logic              latch_slot,
    output logic              odd_group,
    output logic              line_zero,
    output logic              line_end,
    output logic              frame_end
);
    logic [SLOT_W-1:0] slot;
    logic [LINE_W-1:0] line;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot  = SLOT_W'(groups) + SLOT_W'(blank) - SLOT_W'(1);
    assign active     = slot < SLOT_W'(groups);
    assign latch_slot = slot == SLOT_W'(groups);
    assign odd_group  = slot[0];
    assign line_zero  = line == '0;
    assign line_end   = phase && (slot == last_slot);
    assign frame_end  = line_end && (line == lines - LINE_W'(1));

    // Advance phase each clock, slot every second clock, line at slot wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            slot  <= '0;
            line  <= '0;
        end else begin
            phase <= ~phase;
            if (phase) begin
                if (slot == last_slot) begin
                    slot <= '0;
                    line <= frame_end ? '0 : line + LINE_W'(1);
                end else begin
                    slot <= slot + SLOT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lcd_mod_gen.sv
// Backplane bias generator: toggles once per frame when period is 0,
// otherwise after every 'period' line ends.
// Assumes: line_end / frame_end are single-clock strobes from the scanner.
module lcd_mod_gen #(
    parameter int MODCNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_end,
    input  logic                frame_end,
    input  logic [MODCNT_W-1:0] period,
    output logic                mod_state
);
    logic [MODCNT_W-1:0] cnt;

    // Count line ends and flip the bias level at the programmed point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            mod_state <= 1'b0;
        end else if (line_end) begin
            if (period == '0) begin
                cnt <= '0;
                if (frame_end) mod_state <= ~mod_state;
            end else if (cnt == period - MODCNT_W'(1)) begin
                cnt       <= '0;
                mod_state <= ~mod_state;
            end else begin
                cnt <= cnt + MODCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/lcd_pixel_fetch.sv
// Holds the current pixel group. It takes a new group from the stream on
// 'take'. If the stream is empty it keeps the old group and raises a sticky
// underrun flag.
// Assumes: 'take' is the block's own ready strobe.
module lcd_pixel_fetch #(
    parameter int GROUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               s_valid,
    input  logic [GROUP_W-1:0] s_data,
    output logic [GROUP_W-1:0] grp,
    output logic               underrun
);
    // Capture the offered group or flag its absence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp      <= '0;
            underrun <= 1'b0;
        end else if (take) begin
            if (s_valid) grp      <= s_data;
            else         underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/lcd_panel_timing.sv
// Top of the passive LCD timing generator. It combines the scanner, the
// bias generator and the pixel holder, and registers every panel strobe.
// Panel outputs stay low until the first full frame has been scanned.
// Assumes: configuration inputs are static while rst_n is high.
module lcd_panel_timing
    import lcd_timing_pkg::*;
#(
    parameter int HDOT_W   = 10,
    parameter int BLANK_W  = 4,
    parameter int LINE_W   = 9,
    parameter int MODCNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic [HDOT_W-1:0]   cfg_hdots,
    input  logic [BLANK_W-1:0]  cfg_hblank,
    input  logic [LINE_W-1:0]   cfg_lines,
    input  logic [MODCNT_W-1:0] cfg_mod_lines,
    input  logic                s_valid,
    input  logic [7:0]          s_data,
    output logic                s_ready,
    output logic [3:0]          pan_ud,
    output logic [3:0]          pan_ld,
    output logic                pan_shift,
    output logic                pan_latch,
    output logic                pan_mod,
    output logic                pan_frame,
    output logic                pan_en,
    output logic                underrun
);
    localparam int GROUP_W = 8;
    localparam int SLOT_W  = ((HDOT_W > BLANK_W) ? HDOT_W : BLANK_W) + 1;

    logic [HDOT_W-1:0]  groups;
    logic               phase, active, latch_slot, odd_group, line_zero;
    logic               line_end, frame_end, mod_state, en_q, is_dual, is_mono4;
    logic               shift_nxt, mod_nxt;
    logic [GROUP_W-1:0] grp;

    assign is_dual  = cfg_mode == 2'(MODE_COLOR_DUAL);
    assign is_mono4 = cfg_mode == 2'(MODE_MONO4);
    assign groups   = cfg_hdots >> group_shift(cfg_mode);

    lcd_scan_counter #(
        .HDOT_W(HDOT_W), .BLANK_W(BLANK_W), .LINE_W(LINE_W), .SLOT_W(SLOT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .groups(groups), .blank(cfg_hblank),
        .lines(cfg_lines), .phase(phase), .active(active),
        .latch_slot(latch_slot), .odd_group(odd_group), .line_zero(line_zero),
        .line_end(line_end), .frame_end(frame_end)
    );

    lcd_mod_gen #(.MODCNT_W(MODCNT_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
        .period(cfg_mod_lines), .mod_state(mod_state)
    );

    assign s_ready = en_q && active && !phase;

    lcd_pixel_fetch #(.GROUP_W(GROUP_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .take(s_ready), .s_valid(s_valid),
        .s_data(s_data), .grp(grp), .underrun(underrun)
    );

    // Next-cycle levels of the two clock-like pins for the current slot
    always_comb begin
        shift_nxt = 1'b1;
        mod_nxt   = is_dual ? 1'b1 : mod_state;
        if (active) begin
            if (!is_dual)        shift_nxt = !phase;
            else if (odd_group)  mod_nxt   = !phase;
            else                 shift_nxt = !phase;
        end
    end

    // Register panel strobes, gated by the enable that follows frame one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            pan_en    <= 1'b0;
            pan_shift <= 1'b0;
            pan_mod   <= 1'b0;
            pan_latch <= 1'b0;
            pan_frame <= 1'b0;
        end else begin
            en_q      <= en_q | frame_end;
            pan_en    <= en_q;
            pan_shift <= en_q & shift_nxt;
            pan_mod   <= en_q & mod_nxt;
            pan_latch <= en_q & latch_slot;
            pan_frame <= en_q & line_zero;
        end
    end

    assign pan_ud = pan_en ? grp[7:4] : 4'h0;
    assign pan_ld = (pan_en && !is_mono4) ? grp[3:0] : 4'h0;
endmodule

// File: rtl/lcd_panel_timing_chk.sv
// Temporal checks on the ports of lcd_panel_timing, bound to every instance.
// Assumes: cfg_hblank >= 2 and static configuration, as the block requires.
module lcd_panel_timing_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       s_ready,
    input logic [3:0] pan_ud,
    input logic [3:0] pan_ld,
    input logic       pan_shift,
    input logic       pan_latch,
    input logic       pan_mod,
    input logic       pan_frame,
    input logic       pan_en,
    input logic       underrun
);
    // R2
    data_stable_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pan_shift) |-> ($stable(pan_ud) && $stable(pan_ld)));

    // R3
    shift_idle_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pan_latch |-> pan_shift);

    // R4
    frame_held_over_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pan_latch) |-> $stable(pan_frame));

    // R7
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |-> (pan_ld == 4'h0));

    // R9
    outputs_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pan_en |-> (pan_ud == 4'h0 && pan_ld == 4'h0 && !pan_shift
                     && !pan_latch && !pan_mod && !pan_frame));

    // R9
    enable_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pan_en |=> pan_en);

    // R10
    ready_leads_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> (pan_shift && pan_en));

    // R11
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

bind lcd_panel_timing lcd_panel_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .s_ready(s_ready),
    .pan_ud(pan_ud), .pan_ld(pan_ld), .pan_shift(pan_shift),
    .pan_latch(pan_latch), .pan_mod(pan_mod), .pan_frame(pan_frame),
    .pan_en(pan_en), .underrun(underrun)
);

// File: tb/lcd_panel_timing_bench.sv
// Self-checking bench. Random configurations and stream gaps from a fixed
// seed, plus directed cases. Each cycle is compared with a model built
// from the requirements.
module lcd_panel_timing_bench;
    localparam int HW = 10, BW = 4, LW = 9, MW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [HW-1:0] cfg_hdots = '0;
    logic [BW-1:0] cfg_hblank = '0;
    logic [LW-1:0] cfg_lines = '0;
    logic [MW-1:0] cfg_mod_lines = '0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_ready, pan_shift, pan_latch, pan_mod, pan_frame, pan_en, underrun;
    logic [3:0]    pan_ud, pan_ld;

    lcd_panel_timing #(.HDOT_W(HW), .BLANK_W(BW), .LINE_W(LW), .MODCNT_W(MW)) u_lcd_panel_timing (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_hdots(cfg_hdots),
        .cfg_hblank(cfg_hblank), .cfg_lines(cfg_lines), .cfg_mod_lines(cfg_mod_lines),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .pan_ud(pan_ud),
        .pan_ld(pan_ld), .pan_shift(pan_shift), .pan_latch(pan_latch),
        .pan_mod(pan_mod), .pan_frame(pan_frame), .pan_en(pan_en), .underrun(underrun)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // configuration and model state
    int c_mode, c_groups, c_blank, c_lines, c_modl, valid_pct;
    int m_phase, m_slot, m_line, m_cnt;
    bit m_en, m_mod, m_under;
    logic [7:0] m_data;
    int e_shift, e_mod, e_latch, e_frame, e_en, e_ud, e_ld, e_under;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_ready();
        return (m_en && m_slot < c_groups && m_phase == 0) ? 1 : 0;
    endfunction

    // One clock of the requirement model: outputs for the current slot, then advance
    task automatic model_step();
        int  len = c_groups + c_blank;
        bit  act = m_slot < c_groups;
        bit  odd = (m_slot % 2) == 1;
        bit  sh, md, fe;
        sh = act ? ((c_mode == 2 && odd) ? 1'b1 : (m_phase == 0)) : 1'b1;
        md = (c_mode == 2) ? ((act && odd) ? (m_phase == 0) : 1'b1) : m_mod;
        if (exp_ready() == 1) begin
            if (s_valid) m_data = s_data;
            else         m_under = 1'b1;
        end
        e_shift = int'(m_en & sh);
        e_mod   = int'(m_en & md);
        e_latch = int'(m_en && m_slot == c_groups);
        e_frame = int'(m_en && m_line == 0);
        e_en    = int'(m_en);
        e_ud    = m_en ? int'(m_data[7:4]) : 0;
        e_ld    = (m_en && c_mode != 0) ? int'(m_data[3:0]) : 0;
        e_under = int'(m_under);
        if (m_phase == 1 && m_slot == len - 1) begin
            fe = m_line == c_lines - 1;
            if (c_modl == 0) begin
                if (fe) m_mod = !m_mod;
                m_cnt = 0;
            end else if (m_cnt == c_modl - 1) begin
                m_mod = !m_mod;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            m_slot = 0;
            m_line = fe ? 0 : m_line + 1;
            if (fe) m_en = 1'b1;
        end else if (m_phase == 1) begin
            m_slot++;
        end
        m_phase = 1 - m_phase;
    endtask

    task automatic compare_outputs();
        string mt = (c_mode == 2) ? "R8" : ((c_modl == 0) ? "R5" : "R6");
        chk((c_mode == 2) ? "R8" : "R2", "pan_shift", int'(pan_shift), e_shift);
        chk(mt, "pan_mod", int'(pan_mod), e_mod);
        chk("R3", "pan_latch", int'(pan_latch), e_latch);
        chk("R4", "pan_frame", int'(pan_frame), e_frame);
        chk("R9", "pan_en", int'(pan_en), e_en);
        chk("R10", "pan_ud", int'(pan_ud), e_ud);
        chk((c_mode == 0) ? "R7" : "R10", "pan_ld", int'(pan_ld), e_ld);
        chk("R11", "underrun", int'(underrun), e_under);
    endtask

    // Apply configuration and reset, checking the reset state (R1)
    task automatic start(input int mode, input int grps, input int blank,
                         input int lines, input int modl, input int pct);
        c_mode = mode; c_groups = grps; c_blank = blank; c_lines = lines;
        c_modl = modl; valid_pct = pct;
        @(negedge clk);
        rst_n = 1'b0; s_valid = 1'b0;
        cfg_mode = 2'(mode);
        cfg_hdots = HW'(grps << ((mode == 0) ? 2 : 3));
        cfg_hblank = BW'(blank); cfg_lines = LW'(lines); cfg_mod_lines = MW'(modl);
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", int'({pan_ud, pan_ld, pan_shift, pan_latch, pan_mod,
                                         pan_frame, pan_en, underrun, s_ready}), 0);
        m_phase = 0; m_slot = 0; m_line = 0; m_cnt = 0;
        m_en = 1'b0; m_mod = 1'b0; m_under = 1'b0; m_data = 8'h00;
        rst_n = 1'b1;
    endtask

    task automatic run_frames(input int frames);
        int n = frames * 2 * (c_groups + c_blank) * c_lines;
        for (int i = 0; i < n; i++) begin
            s_valid = ($urandom % 100) < valid_pct;
            s_data  = 8'($urandom);
            #1;
            chk("R10", "s_ready", int'(s_ready), exp_ready());
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_outputs();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: 8-bit mono, per-frame bias, full stream
        start(1, 2, 2, 3, 0, 100);  run_frames(5);
        // directed: 4-bit mono, bias every 3 lines, gappy stream
        start(0, 3, 3, 4, 3, 70);   run_frames(5);
        // directed: dual-clock colour, bias period 1 line
        start(2, 4, 2, 2, 1, 100);  run_frames(5);
        // directed: single-line frame, single group, stream never valid
        start(1, 1, 2, 1, 0, 0);    run_frames(6);
        // directed: bias period longer than a frame
        start(3, 2, 4, 2, 5, 90);   run_frames(6);
        // constrained random configurations
        for (int r = 0; r < 10; r++) begin
            start(int'($urandom % 3), 1 + int'($urandom % 6), 2 + int'($urandom % 4),
                  1 + int'($urandom % 5), int'($urandom % 5), 50 + int'($urandom % 51));
            run_frames(5);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL all watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule